// File: doc/BRIEF.md
# Keyed Write Unlock Gate for a Timekeeping Register Bank

This block sits between a simple register write/read port and a slow-domain register bank. Writes to the bank are dropped unless software has first written a 16-bit key word to a dedicated unlock register. A correct key arms the gate for exactly one protected write. A wrong key disarms it. A status bit in the unlock register shows whether the gate is armed.

The gate also models write readiness. When a protected write is passed through, a ready flag in the control register drops. It stays low for a programmable number of slow-clock ticks while the transfer is assumed to be in flight, then rises again. A protected write is accepted only when the gate is armed and ready. A write that is not accepted leaves every piece of state as it was.

Top module: `rtc_write_gate`

## Requirements
- R1: After reset the gate is disarmed, the ready flag is 1 and `bank_we` is 0. A read at address 0x00 returns 0x80, and a read at address 0x3C returns 0.
- R2: A write of the full word 0x0000A55A to address 0x3C arms the gate. After that write, a read at 0x3C returns bit 31 set (0x80000000).
- R3: A write of any other value to address 0x3C disarms the gate, so that a read at 0x3C returns 0. A write to 0x3C never produces a `bank_we` pulse.
- R4: A write to any address other than 0x3C, made while the gate is armed and ready, is accepted. Exactly one clock after the write cycle, `bank_we` is 1 for one cycle, with `bank_addr` and `bank_wdata` equal to the written address and data.
- R5: A write to any address other than 0x3C while the gate is disarmed is dropped. No `bank_we` pulse appears, and the status and ready read values are unchanged.
- R6: An accepted protected write uses up the arming. From the following cycle, the status bit at 0x3C reads 0 until the key is written again.
- R7: After an accepted write, the ready flag (bit 7 of the word read at 0x00) reads 0. It returns to 1 after BUSY_TICKS clock edges at which `slow_tick` is 1.
- R8: A protected write made while the gate is armed but not ready is dropped. No `bank_we` pulse appears, and the gate stays armed.
- R9: Reads at any address other than 0x00 and 0x3C return 0. All bits of the read words other than bit 7 (at 0x00) and bit 31 (at 0x3C) are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow-domain clock period |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data: ready flag or armed status |
| bank_we | output | 1 | Qualified write strobe to the protected bank |
| bank_addr | output | ADDR_W | Address of the qualified write |
| bank_wdata | output | 32 | Data of the qualified write |

## Verification
The assertions take for granted that `wr_en` is a single-cycle request whose address and data are valid in that cycle. They also assume that `slow_tick` may arrive in any cycle, including the cycle of an accepted write, where the reload has priority. The random stimulus keeps within this by driving a fresh write request, or none, in every cycle and toggling `slow_tick` freely. It mixes correct keys, wrong keys, and protected writes at arbitrary addresses, so that writes land in the armed, disarmed and busy states alike. Directed cases cover a write arriving while the gate is busy and a wrong key following a correct one.

// File: rtl/rtc_wgate_pkg.sv
package rtc_wgate_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'h0000_A55A;
  localparam int READY_POS  = 7;
  localparam int STATUS_POS = 31;

  function automatic logic key_match(input logic [WORD_W-1:0] d);
    return d == UNLOCK_KEY;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input logic rdy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[READY_POS] = rdy;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic armed);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STATUS_POS] = armed;
    return w;
  endfunction
endpackage

// File: rtl/rtc_wgate_key.sv
module rtc_wgate_key
  import rtc_wgate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [WORD_W-1:0] key_data,
  input  logic              consume,
  output logic              armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (key_wr)  armed <= key_match(key_data);
    else if (consume) armed <= 1'b0;
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_match(key_data)) |=> armed); // R2
  AST_BADKEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !key_match(key_data)) |=> !armed); // R3
  AST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !armed); // R6
endmodule

// File: rtl/rtc_wgate_timer.sv
module rtc_wgate_timer #(
  parameter int BUSY_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic ready
);
  localparam int CNT_W = $clog2(BUSY_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_TICKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (start)                  cnt <= LOAD;
    else if (tick && cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !tick && !start) |=> $stable(cnt)); // R7
  AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ready); // R8
endmodule

// File: rtl/rtc_write_gate.sv
module rtc_write_gate
  import rtc_wgate_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUSY_TICKS  = 3,
  parameter int UNLOCK_ADDR = 'h3C,
  parameter int CTRL_ADDR   = 'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              bank_we,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [WORD_W-1:0] bank_wdata
);
  localparam logic [ADDR_W-1:0] UNL_A = ADDR_W'(UNLOCK_ADDR);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTRL_ADDR);

  logic key_wr, prot_wr, accept, armed, wr_ready;

  assign key_wr  = wr_en && (wr_addr == UNL_A);
  assign prot_wr = wr_en && (wr_addr != UNL_A);
  assign accept  = prot_wr && armed && wr_ready;

  rtc_wgate_key u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(wr_data),
    .consume(accept), .armed(armed)
  );

  rtc_wgate_timer #(.BUSY_TICKS(BUSY_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .tick(slow_tick), .ready(wr_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_we    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
    end else begin
      bank_we <= accept;
      if (accept) begin
        bank_addr  <= wr_addr;
        bank_wdata <= wr_data;
      end
    end
  end

  always_comb begin
    if (rd_addr == CTL_A)      rd_data = ctrl_word(wr_ready);
    else if (rd_addr == UNL_A) rd_data = status_word(armed);
    else                       rd_data = '0;
  end

  AST_WE_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> $past(armed && wr_ready)); // R4
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> !bank_we); // R4
  AST_DROP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && !armed) |=> (!bank_we && !armed)); // R5
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_wr && armed && !wr_ready) |=> (!bank_we && armed)); // R8
  AST_USED_UP: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> (!armed && !wr_ready)); // R6
  AST_KEY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> !bank_we); // R3
endmodule

// File: tb/rtc_write_gate_bench.sv
module rtc_write_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int BT = 3;
  localparam logic [AW-1:0] UNL = 8'h3C;
  localparam logic [AW-1:0] CTL = 8'h00;
  localparam logic [31:0] KEY = 32'h0000A55A;

  logic clk = 0, rst_n = 0, slow_tick = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, bank_addr;
  logic [31:0] wr_data = '0, rd_data, bank_wdata;
  logic bank_we;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_arm = 0;
  int m_cnt = 0;
  bit m_we = 0;
  logic [AW-1:0] m_addr = '0;
  logic [31:0] m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_write_gate #(.ADDR_W(AW), .BUSY_TICKS(BT)) u_rtc_write_gate (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata)
  );

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input bit arm, input int cnt);
    if (a == CTL) return (cnt == 0) ? 32'h80 : 32'h0;
    if (a == UNL) return arm ? 32'h8000_0000 : 32'h0;
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus, update the model, then compare outputs
  task automatic step(input bit we, input logic [AW-1:0] a, input logic [31:0] d,
                      input bit tk, input logic [AW-1:0] ra, input string tag);
    bit acc;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; slow_tick = tk; rd_addr = ra;
    acc = we && (a != UNL) && m_arm && (m_cnt == 0);
    if (we && a == UNL) m_arm = (d == KEY);
    if (acc) begin
      m_arm = 0; m_cnt = BT; m_addr = a; m_data = d;
    end else if (tk && m_cnt > 0) m_cnt--;
    m_we = acc;
    @(posedge clk); #1;
    wr_en = 0;
    check({tag, " bank_we"}, {31'b0, bank_we}, {31'b0, m_we});
    if (m_we) begin
      check({tag, " bank_addr"}, {24'b0, bank_addr}, {24'b0, m_addr});
      check({tag, " bank_wdata"}, bank_wdata, m_data);
    end
    check({tag, " rd_data"}, rd_data, exp_read(ra, m_arm, m_cnt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 bank_we", {31'b0, bank_we}, 32'h0);
    rd_addr = CTL; #1; check("R1 ready", rd_data, 32'h80);
    rd_addr = UNL; #1; check("R1 status", rd_data, 32'h0);
    @(negedge clk); rst_n = 1;

    // R5 locked write dropped
    step(1, 8'h04, 32'h1111_2222, 0, UNL, "R5 locked status");
    step(0, 0, 0, 0, CTL, "R5 locked ready");
    // R2 key arms
    step(1, UNL, KEY, 0, UNL, "R2 armed");
    // R3 wrong key disarms
    step(1, UNL, 32'h0001_A55A, 0, UNL, "R3 wrong key");
    step(1, UNL, KEY, 0, UNL, "R2 rearm");
    // R4 accepted write, R6 consumed
    step(1, 8'h08, 32'hDEAD_BEEF, 0, UNL, "R4 R6 accept");
    // R7 ready low, returns after BT ticks
    step(0, 0, 0, 1, CTL, "R7 busy1");
    step(1, UNL, KEY, 0, CTL, "R7 busy hold");
    // R8 armed but busy: dropped, stays armed
    step(1, 8'h0C, 32'h5555_0000, 0, UNL, "R8 busy drop");
    step(0, 0, 0, 1, CTL, "R7 busy2");
    step(0, 0, 0, 1, CTL, "R7 ready back");
    step(1, 8'h00, 32'h0000_00FF, 0, UNL, "R4 R6 accept ctrl");
    step(0, 0, 0, 0, 8'h10, "R9 other addr");

    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [AW-1:0] a;
      logic [31:0] d;
      logic [AW-1:0] ra;
      op = $urandom_range(0, 9);
      a = AW'($urandom);
      d = $urandom;
      case ($urandom_range(0, 2))
        0: ra = CTL;
        1: ra = UNL;
        default: ra = AW'($urandom);
      endcase
      if (op < 3)      step(1, UNL, KEY, $urandom_range(0,1), ra, "R2 rnd key");
      else if (op < 4) step(1, UNL, d, $urandom_range(0,1), ra, "R3 rnd badkey");
      else if (op < 8) step(1, (a == UNL) ? 8'h04 : a, d, $urandom_range(0,1), ra, "R4 R5 R8 rnd write");
      else             step(0, 0, 0, $urandom_range(0,1), ra, "R7 R9 rnd idle");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule